// File: doc/BRIEF.md
# Virtual address translation unit

This unit turns a 32-bit virtual address into a physical address for one of three access kinds: instruction fetch, data read or data write. Two high windows of the address space skip translation. One window strips the top three bits, and the other passes the address through unchanged. In user mode most of those windows are closed and raise an address error. All other addresses go to a small fully associative translation table when translation is enabled. When translation is disabled, they are simply truncated to 29 bits.

Each table entry selects its own page size. An entry can be shared across address-space identifiers. The table detects when more than one entry matches an address. A lookup produces one of two results:
- a physical address together with read, write and execute permission bits, or
- a twelve-bit fault code, together with the faulting address and its page number, both held for the exception handler.

A six-bit replacement counter advances on every table lookup, and software-style entry loads write the slot that the counter names. A request is sampled on a rising edge, and its result appears on the response outputs at the following edge.

Top module: `vat_unit`

## Requirements
- R1: Addresses 0x80000000 to 0xBFFFFFFF map to the address with bits 31:29 cleared, and addresses at or above 0xE0000000 map to themselves. Both give rsp_perm = 3'b111 (bit 2 read, bit 1 write, bit 0 execute) and rsp_exc = 0, and neither advances the replacement counter.
- R2: With priv low, an access to those windows outside 0xE0000000 to 0xE3FFFFFF gives code 0x0E0 for a read or fetch and 0x100 for a write (req_kind 0 = read, 1 = write, 2 = fetch). A fault response always carries rsp_perm = 0 and rsp_paddr = 0.
- R3: With xlat_en low, every other address maps to the address with bits 31:29 cleared, with rsp_perm = 3'b111, and does not advance the counter.
- R4: An entry's size code gives the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The stored page numbers are counted in 1 KB units and are aligned down to the page size. The physical address is the aligned physical page joined with the virtual offset below the page size.
- R5: The entry's ASID must equal cur_asid when single_virt is low or priv is low. A shared entry matches any ASID.
- R6: An entry with its valid bit clear never matches. No match gives 0x040 for a read or fetch and 0x060 for a write.
- R7: Two or more matching entries give 0x140 and leave pteh_vpn unchanged.
- R8: With priv low, an entry whose protection bit 1 is clear gives 0x0A0 for a read or fetch and 0x0C0 for a write. A write to an entry whose protection bit 0 is clear gives 0x0C0 in either mode.
- R9: An otherwise permitted write to an entry whose dirty bit is clear gives 0x080. A successful table hit grants read and execute, and it grants write only when protection bit 0 and the dirty bit are both set.
- R10: repl_idx increments by one on each table lookup. It returns to 0 when the incremented value exceeds a nonzero repl_bound or exceeds ENTRIES-1.
- R11: A cycle with ld_en high writes slot repl_idx from two inputs:
  - pte_hi: bits 31:10 hold the virtual page and bits 7:0 hold the ASID.
  - pte_lo: bits 31:10 hold the physical page, bit 8 is valid, bits 6:5 are the protection bits, bits 4:3 are the size code, bit 2 is dirty and bit 1 is shared.
- R12: The result of a request sampled at one edge appears at the next edge. Any fault loads fault_addr with the request address. Any fault other than a multiple hit also loads pteh_vpn with address bits 31:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| priv | input | 1 | Privileged mode |
| xlat_en | input | 1 | Translation enable |
| single_virt | input | 1 | Single virtual space mode |
| cur_asid | input | 8 | Current address-space identifier |
| repl_bound | input | 6 | Replacement counter boundary, 0 means none |
| ld_en | input | 1 | Load an entry into slot repl_idx |
| pte_hi | input | 32 | Entry high word (page, ASID) |
| pte_lo | input | 32 | Entry low word (frame, flags) |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Read, write, execute |
| rsp_exc | output | 12 | Fault code, 0 for success |
| fault_addr | output | 32 | Last faulting virtual address |
| pteh_vpn | output | 22 | Page number of last non-multiple fault |
| repl_idx | output | 6 | Replacement counter |

## Verification
The bench targets the following corner cases:
- A 1 MB shared entry that is loaded with unaligned page numbers. A design that skipped alignment would return a wrong frame, and one that ignored the shared bit would report a miss.
- An entry that overlaps another entry. A design that took the first hit would return a valid address instead of 0x140, or would overwrite pteh_vpn.
- A write to a clean page versus a write to a read-only page. Swapping their priority would turn 0x0C0 into 0x080.
- The counter wrapping at the last index and at a nonzero boundary, and its holding still on untranslated and disabled accesses. An off-by-one here misplaces every later load.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int VA_W   = 32;
    localparam int PG_W   = 22;   // page number in 1 KB units
    localparam int ASID_W = 8;
    localparam int EXC_W  = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } access_e;

    localparam logic [EXC_W-1:0] EXC_NONE     = 12'h000;
    localparam logic [EXC_W-1:0] EXC_MISS_RD  = 12'h040;
    localparam logic [EXC_W-1:0] EXC_MISS_WR  = 12'h060;
    localparam logic [EXC_W-1:0] EXC_FIRST_WR = 12'h080;
    localparam logic [EXC_W-1:0] EXC_PROT_RD  = 12'h0A0;
    localparam logic [EXC_W-1:0] EXC_PROT_WR  = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_ADDR_RD  = 12'h0E0;
    localparam logic [EXC_W-1:0] EXC_ADDR_WR  = 12'h100;
    localparam logic [EXC_W-1:0] EXC_MULTI    = 12'h140;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        logic [1:0]        size;
        logic [ASID_W-1:0] asid;
        logic [PG_W-1:0]   vpn;
        logic [PG_W-1:0]   ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic [EXC_W-1:0] exc;
        logic [VA_W-1:0]  paddr;
        logic [2:0]       perm;   // read, write, execute
    } xlat_result_t;

    // Mask of the page-number bits that survive alignment to the page size
    function automatic logic [PG_W-1:0] page_mask(input logic [1:0] size);
        case (size)
            2'd0:    page_mask = {PG_W{1'b1}};
            2'd1:    page_mask = {{(PG_W-2){1'b1}}, 2'b0};
            2'd2:    page_mask = {{(PG_W-6){1'b1}}, 6'b0};
            default: page_mask = {{(PG_W-10){1'b1}}, 10'b0};
        endcase
    endfunction

    function automatic tlb_entry_t unpack_entry(input logic [31:0] hi,
                                                input logic [31:0] lo);
        tlb_entry_t e;
        e.vpn    = hi[31:10];
        e.asid   = hi[7:0];
        e.ppn    = lo[31:10];
        e.valid  = lo[8];
        e.prot   = lo[6:5];
        e.size   = lo[4:3];
        e.dirty  = lo[2];
        e.shared = lo[1];
        return e;
    endfunction

endpackage

// File: rtl/vat_region.sv
module vat_region
    import vat_pkg::*;
(
    input  logic [VA_W-1:0] addr,
    input  logic            priv,
    output logic            fixed,
    output logic            addr_err,
    output logic [VA_W-1:0] fixed_paddr
);
    logic in_low_win;
    logic in_top_win;
    logic in_queue_win;

    always_comb begin
        in_low_win   = (addr[31:30] == 2'b10);
        in_top_win   = (addr[31:29] == 3'b111);
        in_queue_win = (addr[31:26] == 6'b111000);
        fixed        = in_low_win || in_top_win;
        addr_err     = fixed && !priv && !in_queue_win;
        fixed_paddr  = in_low_win ? {3'b000, addr[28:0]} : addr;
    end
endmodule

// File: rtl/vat_repl_ctr.sv
module vat_repl_ctr #(
    parameter int ENTRIES = 16,
    parameter int CTR_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [CTR_W-1:0] bound,
    output logic [CTR_W-1:0] cnt
);
    localparam logic [CTR_W:0] LAST = (CTR_W+1)'(ENTRIES - 1);

    logic [CTR_W:0] inc;
    logic           wrap;

    always_comb begin
        inc  = {1'b0, cnt} + 1'b1;
        wrap = ((bound != '0) && (inc > {1'b0, bound})) || (inc > LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= wrap ? '0 : inc[CTR_W-1:0];
    end

    AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt} <= LAST);                               // R10
    AST_CTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));                             // R10
endmodule

// File: rtl/vat_tlb.sv
module vat_tlb
    import vat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [PG_W-1:0]   look_pg,
    input  logic [ASID_W-1:0] look_asid,
    input  logic              use_asid,
    output logic              any_hit,
    output logic              multi_hit,
    output tlb_entry_t        hit_entry
);
    tlb_entry_t         slots [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [PG_W-1:0] m;
        logic            asid_ok;

        always_ff @(posedge clk) begin
            if (rst)
                slots[i].valid <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                slots[i] <= wr_entry;
        end

        always_comb begin
            m          = page_mask(slots[i].size);
            asid_ok    = slots[i].shared || !use_asid || (slots[i].asid == look_asid);
            hit_vec[i] = slots[i].valid && asid_ok &&
                         ((look_pg & m) == (slots[i].vpn & m));
        end
    end

    always_comb begin
        logic seen;
        seen      = 1'b0;
        multi_hit = 1'b0;
        hit_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                multi_hit = multi_hit || seen;
                seen      = 1'b1;
                hit_entry = hit_entry | slots[i];
            end
        end
        any_hit = seen;
    end

    AST_MULTI_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> ($countones(hit_vec) > 1));           // R7
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CTR_W   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic        priv,
    input  logic        xlat_en,
    input  logic        single_virt,
    input  logic [7:0]  cur_asid,
    input  logic [5:0]  repl_bound,
    input  logic        ld_en,
    input  logic [31:0] pte_hi,
    input  logic [31:0] pte_lo,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_perm,
    output logic [11:0] rsp_exc,
    output logic [31:0] fault_addr,
    output logic [21:0] pteh_vpn,
    output logic [5:0]  repl_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic            fixed, addr_err;
    logic [VA_W-1:0] fixed_paddr;
    logic            any_hit, multi_hit;
    tlb_entry_t      ent;
    logic            is_write, use_asid, tlb_go;
    logic [CTR_W-1:0] cnt;
    xlat_result_t    nxt;
    logic [PG_W-1:0] m;
    logic            unused_bits;

    assign unused_bits = ^{pte_hi[9:8], pte_lo[9], pte_lo[7], pte_lo[0]};

    vat_region u_region (
        .addr        (req_addr),
        .priv        (priv),
        .fixed       (fixed),
        .addr_err    (addr_err),
        .fixed_paddr (fixed_paddr)
    );

    vat_repl_ctr #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (tlb_go),
        .bound (CTR_W'(repl_bound)),
        .cnt   (cnt)
    );

    vat_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ld_en),
        .wr_idx    (cnt[IDX_W-1:0]),
        .wr_entry  (unpack_entry(pte_hi, pte_lo)),
        .look_pg   (req_addr[31:10]),
        .look_asid (cur_asid),
        .use_asid  (use_asid),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .hit_entry (ent)
    );

    assign repl_idx = 6'(cnt);

    always_comb begin
        is_write = (req_kind == ACC_WRITE);
        use_asid = !single_virt || !priv;
        tlb_go   = req_valid && !fixed && xlat_en;
        m        = page_mask(ent.size);
        nxt      = '0;
        if (fixed) begin
            if (addr_err) nxt.exc = is_write ? EXC_ADDR_WR : EXC_ADDR_RD;
            else begin
                nxt.paddr = fixed_paddr;
                nxt.perm  = 3'b111;
            end
        end else if (!xlat_en) begin
            nxt.paddr = {3'b000, req_addr[28:0]};
            nxt.perm  = 3'b111;
        end else if (!any_hit) begin
            nxt.exc = is_write ? EXC_MISS_WR : EXC_MISS_RD;
        end else if (multi_hit) begin
            nxt.exc = EXC_MULTI;
        end else if (!priv && !ent.prot[1]) begin
            nxt.exc = is_write ? EXC_PROT_WR : EXC_PROT_RD;
        end else if (is_write && !ent.prot[0]) begin
            nxt.exc = EXC_PROT_WR;
        end else if (is_write && !ent.dirty) begin
            nxt.exc = EXC_FIRST_WR;
        end else begin
            nxt.paddr = {ent.ppn & m, 10'b0} | (req_addr & {~m, 10'h3FF});
            nxt.perm  = {1'b1, ent.prot[0] && ent.dirty, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_perm   <= '0;
            rsp_exc    <= '0;
            fault_addr <= '0;
            pteh_vpn   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= nxt.paddr;
                rsp_perm  <= nxt.perm;
                rsp_exc   <= nxt.exc;
                if (nxt.exc != EXC_NONE) begin
                    fault_addr <= req_addr;
                    if (nxt.exc != EXC_MULTI) pteh_vpn <= req_addr[31:10];
                end
            end
        end
    end

    AST_FAULT_LATCHES_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_exc != 12'h0) |-> fault_addr == $past(req_addr));   // R12
    AST_MULTI_KEEPS_VPN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_exc == 12'h140) |-> $stable(pteh_vpn));              // R7
    AST_WRITE_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_perm[1]) |-> rsp_exc == 12'h0);                      // R9
    AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_exc != 12'h0) |-> (rsp_perm == 3'b0));               // R2
    AST_FIXED_NO_ADV: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fixed) |=> $stable(repl_idx));                           // R1
endmodule

// File: tb/tb_vat_unit.sv
module tb_vat_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        priv = 1'b1;
    logic        xlat_en = 1'b1;
    logic        single_virt = 1'b0;
    logic [7:0]  cur_asid = 8'd5;
    logic [5:0]  repl_bound = '0;
    logic        ld_en = 1'b0;
    logic [31:0] pte_hi = '0;
    logic [31:0] pte_lo = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [11:0] rsp_exc;
    logic [31:0] fault_addr;
    logic [21:0] pteh_vpn;
    logic [5:0]  repl_idx;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [46:0] exp_q [$];   // {exc, paddr, perm}
    string       tag_q [$];

    always #5 clk = ~clk;

    vat_unit dut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] k,
                          input logic [11:0] e_exc, input logic [31:0] e_pa,
                          input logic [2:0] e_perm, input string tag);
        @(negedge clk);
        req_addr  = a;
        req_kind  = k;
        req_valid = 1'b1;
        exp_q.push_back({e_exc, e_pa, e_perm});
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        pte_hi = hi;
        pte_lo = lo;
        ld_en  = 1'b1;
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    task automatic ctr_is(input logic [5:0] e, input string tag);
        check(repl_idx == e, tag, 64'(repl_idx), 64'(e));
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", 64'(rsp_exc), 64'hFFFF);
            end else begin
                logic [46:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rsp_exc, rsp_paddr, rsp_perm} == e, t,
                      64'({rsp_exc, rsp_paddr, rsp_perm}), 64'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rsp_valid == 1'b0, "R12 reset valid", 64'(rsp_valid), 0);
        ctr_is(6'd0, "R10 reset counter");

        // R11 slot0: 4 KB page 0x00400000 -> 0x00800000, rw, dirty, asid 5
        load(32'h0040_0005, 32'h0080_016C);
        lookup(32'h0040_0ABC, 2'd0, 12'h000, 32'h0080_0ABC, 3'b111, "R4 4KB read");
        ctr_is(6'd1, "R10 advance");
        // R11 slot1: shared 1 MB, unaligned page numbers, user read only, clean
        load(32'h1001_2C07, 32'h0AB4_5D5A);
        priv = 1'b0;
        lookup(32'h100F_EDCB, 2'd0, 12'h000, 32'h0ABF_EDCB, 3'b101, "R4 R5 shared 1MB aligned");
        priv = 1'b1;
        lookup(32'h1000_0000, 2'd1, 12'h0C0, 32'h0, 3'b000, "R8 write no prot0");
        ctr_is(6'd3, "R10 count three");
        // slot3: 1 KB clean page
        load(32'h2000_0005, 32'h0030_0160);
        lookup(32'h2000_0010, 2'd1, 12'h080, 32'h0, 3'b000, "R9 first write");
        lookup(32'h2000_0010, 2'd0, 12'h000, 32'h0030_0010, 3'b101, "R9 clean no write perm");
        lookup(32'h3000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R6 miss read");
        lookup(32'h3000_0004, 2'd1, 12'h060, 32'h0, 3'b000, "R6 miss write");
        check(fault_addr == 32'h3000_0004, "R12 fault addr", 64'(fault_addr), 64'h30000004);
        check(pteh_vpn == 22'h0C_0000, "R12 vpn latch", 64'(pteh_vpn), 64'hC0000);
        cur_asid = 8'd6;
        lookup(32'h0040_0000, 2'd2, 12'h040, 32'h0, 3'b000, "R5 asid mismatch");
        single_virt = 1'b1;
        lookup(32'h0040_0004, 2'd2, 12'h000, 32'h0080_0004, 3'b111, "R5 single virtual priv");
        single_virt = 1'b0;
        cur_asid = 8'd5;
        ctr_is(6'd9, "R10 count nine");
        // slot9: supervisor-only 4 KB page
        load(32'h4000_0005, 32'h0050_012C);
        priv = 1'b0;
        lookup(32'h4000_0020, 2'd0, 12'h0A0, 32'h0, 3'b000, "R8 user read");
        lookup(32'h4000_0020, 2'd1, 12'h0C0, 32'h0, 3'b000, "R8 user write");
        priv = 1'b1;
        lookup(32'h4000_0020, 2'd1, 12'h000, 32'h0050_0020, 3'b111, "R8 R9 supervisor write");
        // slot12: 64 KB page overlapping slot0
        load(32'h0040_0005, 32'h0090_0174);
        lookup(32'h0040_0100, 2'd0, 12'h140, 32'h0, 3'b000, "R7 multiple hit");
        check(pteh_vpn == 22'h10_0000, "R7 vpn kept", 64'(pteh_vpn), 64'h100000);
        check(fault_addr == 32'h0040_0100, "R7 fault addr", 64'(fault_addr), 64'h00400100);
        // slot13: invalid entry
        load(32'h5000_0005, 32'h0060_006C);
        lookup(32'h5000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R6 invalid entry");
        ctr_is(6'd14, "R10 count fourteen");
        lookup(32'hA123_4567, 2'd0, 12'h000, 32'h0123_4567, 3'b111, "R1 low window");
        lookup(32'hFF00_0010, 2'd1, 12'h000, 32'hFF00_0010, 3'b111, "R1 top window");
        priv = 1'b0;
        lookup(32'h8000_0000, 2'd0, 12'h0E0, 32'h0, 3'b000, "R2 user read");
        lookup(32'hF000_0000, 2'd1, 12'h100, 32'h0, 3'b000, "R2 user write");
        lookup(32'hE000_1000, 2'd2, 12'h000, 32'hE000_1000, 3'b111, "R2 queue window open");
        priv = 1'b1;
        ctr_is(6'd14, "R1 counter held");
        lookup(32'hC000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R6 translated high");
        ctr_is(6'd15, "R10 last index");
        lookup(32'h3000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R6 miss");
        ctr_is(6'd0, "R10 wrap last");
        xlat_en = 1'b0;
        lookup(32'h7FFF_FFFF, 2'd1, 12'h000, 32'h1FFF_FFFF, 3'b111, "R3 disabled");
        ctr_is(6'd0, "R3 counter held");
        xlat_en = 1'b1;
        repl_bound = 6'd2;
        lookup(32'h3000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R10 b1");
        lookup(32'h3000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R10 b2");
        ctr_is(6'd2, "R10 at bound");
        lookup(32'h3000_0000, 2'd0, 12'h040, 32'h0, 3'b000, "R10 b3");
        ctr_is(6'd0, "R10 wrap bound");
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R12 responses drained", 64'(exp_q.size()), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule